// File: doc/BRIEF.md
# Grouped Multi-Rail Power Sequencer

This block brings a board's voltage regulators up in a fixed series of groups and takes them down again in the reverse series. It drives one enable pin per regulator (22 in all) and watches one power-good pin per monitored regulator (15 in all). Bring-up waits for an external module-enable request. All enables of a group switch on together. The next group follows only when every monitored rail of the current group has stayed good for a filter window. Once the last group is good, the block raises a module power-good output and releases an active-low system reset.

A per-stage watchdog turns a stuck bring-up into a latched fault. The loss of a power-good that the sequence has already passed is also a latched fault. Either fault, or the withdrawal of the module-enable request, starts a stepped teardown. The module power-good and the system reset drop at once, and the groups then switch off highest first, one group per fixed delay. Power-good pins idle high through board pull-ups, so a rail left unconnected counts as good. A status pair reports the current stage code and a snapshot of the filtered power-good vector; the snapshot is frozen while a fault is latched. The block has no streaming data path, so every pin is a plain level signal.

Top module: `pwr_group_seq`

## Requirements
- R1: While rst_ni is low and on the first cycle after it, all rail_en_o bits, mod_pgood_o and fault_o are 0, sys_rst_no is 0 and stat_stage_o is 0.
- R2: In stage 0 no rail enable is driven and the block stays in stage 0 for as long as mod_en_i is low, whatever pg_i reads.
- R3: Enable bit layout by group: group 1 = bits [2:0], group 2 = bits [9:3], group 3 = bits [13:10], group 4 = bits [20:14], group 5 = bit [21]. In stage k (1 to 5) exactly groups 1 to k are enabled, so rail_en_o is always a run of ones from bit 0, and it grows by one group per step.
- R4: Power-good bit layout by group: group 1 = bits [2:0], group 2 = bits [6:3], group 3 = bits [10:7], group 4 = bits [13:11], group 5 = bit [14]. The block leaves stage k only when every pg_i bit of group k is good; enables without a power-good bit never hold up the advance, and pins tied high pass straight through.
- R5: Each pg_i bit passes a two-flop synchronizer and counts as good only after staying high for FILT_CYC consecutive cycles; a shorter high pulse causes no advance.
- R6: When group 5 is good the block enters stage 6: mod_pgood_o and sys_rst_no go to 1 with all 22 enables on.
- R7: If group k is not good within TIMEOUT_CYC cycles of entering stage k, fault_o goes to 1 and teardown starts.
- R8: While in a stage above a group, or in stage 6, a filtered power-good bit of a group already passed going low sets fault_o and starts teardown.
- R9: mod_en_i going low during bring-up or in stage 6 starts teardown without setting fault_o, and the block ends in stage 0.
- R10: During teardown, stat_stage_o reads 7 and mod_pgood_o and sys_rst_no are 0 from its first cycle. The enabled groups then switch off highest first, one group every DOWN_DLY cycles, before any lower group changes.
- R11: After a faulted teardown the block holds all enables off with fault_o=1 and stat_stage_o=7 until mod_en_i goes low. It then returns to stage 0 with fault_o cleared.
- R12: stat_stage_o reads 0 when idle, k in stage k (1 to 5), 6 when up, and 7 in teardown or fault. stat_pg_o follows the filtered power-good vector and holds its value from the edge at which fault_o rises for as long as fault_o stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mod_en_i | input | 1 | Module enable request (asynchronous, synchronized inside) |
| pg_i | input | 15 | Raw power-good inputs, layout per R4 |
| rail_en_o | output | 22 | Regulator enables, layout per R3 |
| mod_pgood_o | output | 1 | Module-level power good |
| sys_rst_no | output | 1 | Active-low system reset |
| fault_o | output | 1 | Latched fault flag |
| stat_stage_o | output | 3 | Stage code per R12 |
| stat_pg_o | output | 15 | Filtered power-good snapshot |

## Verification
The hardest state to reach from the ports is a fault partway through bring-up in which the snapshot holds a mixed pattern. To reach it, the stimulus holds only group 1 good until the stage 2 watchdog expires. It then drives every power-good pin low and confirms that the snapshot still shows the pattern from the moment of the fault. The stepped teardown is checked cycle by cycle: the bench records each change of the enable vector after module enable drops, and compares the group that switched off and the spacing to the previous change. The filter threshold is checked with a power-good pulse one cycle shorter than the window.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  localparam int NGRP = 5;
  localparam int EN_W = 22;
  localparam int PG_W = 15;
  localparam int EN_CNT [NGRP] = '{3, 7, 4, 7, 1};
  localparam int PG_CNT [NGRP] = '{3, 4, 4, 3, 1};

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RAMP  = 3'd1,
    S_ON    = 3'd2,
    S_DOWN  = 3'd3,
    S_FAULT = 3'd4
  } seq_state_e;

  // enables of groups 1..lvl, packed from bit 0
  function automatic logic [EN_W-1:0] en_prefix(input logic [2:0] lvl);
    int n;
    logic [EN_W-1:0] m;
    n = 0;
    for (int i = 0; i < NGRP; i++) if (i < int'(lvl)) n += EN_CNT[i];
    for (int b = 0; b < EN_W; b++) m[b] = (b < n);
    return m;
  endfunction

  // power-good bits of groups 1..lvl, packed from bit 0
  function automatic logic [PG_W-1:0] pg_prefix(input logic [2:0] lvl);
    int n;
    logic [PG_W-1:0] m;
    n = 0;
    for (int i = 0; i < NGRP; i++) if (i < int'(lvl)) n += PG_CNT[i];
    for (int b = 0; b < PG_W; b++) m[b] = (b < n);
    return m;
  endfunction

  // power-good bits of group lvl only (lvl >= 1)
  function automatic logic [PG_W-1:0] pg_group(input logic [2:0] lvl);
    return pg_prefix(lvl) & ~pg_prefix(lvl - 3'd1);
  endfunction

endpackage

// File: rtl/pseq_bit_sync.sv
module pseq_bit_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pseq_pg_filter.sv
module pseq_pg_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pg_raw_i,
  output logic good_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          pg_s;
  logic [CW-1:0] run_q;

  pseq_bit_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pg_raw_i),
    .q_o    (pg_s)
  );

  // count consecutive synchronized-high cycles, saturate at the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       run_q <= '0;
    else if (!pg_s)                    run_q <= '0;
    else if (run_q != CW'(FILT_CYC))   run_q <= run_q + 1'b1;
  end

  assign good_o = (run_q == CW'(FILT_CYC));

  // a rail can only become good after a synchronized-high cycle
  assert_filter_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(good_o) |-> $past(pg_s));

endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
  import pseq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 250000,
  parameter int DOWN_DLY    = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_s_i,
  input  logic [PG_W-1:0] pg_good_i,
  output logic [EN_W-1:0] rail_en_o,
  output logic            pgood_o,
  output logic            rst_no,
  output logic            fault_o,
  output logic [2:0]      stage_o,
  output logic [PG_W-1:0] snap_o
);
  localparam int TMAX = (TIMEOUT_CYC > DOWN_DLY) ? TIMEOUT_CYC : DOWN_DLY;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [2:0] TOP_LVL = 3'(NGRP);

  seq_state_e      state_q, state_d;
  logic [2:0]      lvl_q, lvl_d, lvl_m1;
  logic [TW-1:0]   tmr_q, tmr_d;
  logic            fault_q, fault_d;
  logic [PG_W-1:0] snap_q;
  logic [PG_W-1:0] grp_mask, valid_mask;
  logic            grp_good, loss;

  assign lvl_m1     = (lvl_q == 3'd0) ? 3'd0 : lvl_q - 3'd1;
  assign grp_mask   = pg_group(lvl_q);
  assign grp_good   = &(pg_good_i | ~grp_mask);
  assign valid_mask = (state_q == S_ON)   ? pg_prefix(TOP_LVL) :
                      (state_q == S_RAMP) ? pg_prefix(lvl_m1)  : '0;
  assign loss       = |(valid_mask & ~pg_good_i);

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    tmr_d   = tmr_q;
    fault_d = fault_q;
    unique case (state_q)
      S_IDLE: begin
        if (en_s_i) begin
          state_d = S_RAMP;
          lvl_d   = 3'd1;
          tmr_d   = '0;
        end
      end
      S_RAMP: begin
        if (!en_s_i) begin
          state_d = S_DOWN;
          tmr_d   = '0;
        end else if (loss) begin
          state_d = S_DOWN;
          fault_d = 1'b1;
          tmr_d   = '0;
        end else if (grp_good) begin
          tmr_d = '0;
          if (lvl_q == TOP_LVL) state_d = S_ON;
          else                  lvl_d   = lvl_q + 3'd1;
        end else if (tmr_q == TW'(TIMEOUT_CYC - 1)) begin
          state_d = S_DOWN;
          fault_d = 1'b1;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      S_ON: begin
        tmr_d = '0;
        if (!en_s_i) begin
          state_d = S_DOWN;
        end else if (loss) begin
          state_d = S_DOWN;
          fault_d = 1'b1;
        end
      end
      S_DOWN: begin
        if (tmr_q == TW'(DOWN_DLY - 1)) begin
          tmr_d = '0;
          lvl_d = lvl_q - 3'd1;
          if (lvl_q <= 3'd1) state_d = fault_q ? S_FAULT : S_IDLE;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      S_FAULT: begin
        if (!en_s_i) begin
          state_d = S_IDLE;
          fault_d = 1'b0;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      lvl_q   <= '0;
      tmr_q   <= '0;
      fault_q <= 1'b0;
      snap_q  <= '0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      tmr_q   <= tmr_d;
      fault_q <= fault_d;
      if (!fault_q) snap_q <= pg_good_i;
    end
  end

  assign rail_en_o = en_prefix(lvl_q);
  assign pgood_o   = (state_q == S_ON);
  assign rst_no    = (state_q == S_ON);
  assign fault_o   = fault_q;
  assign snap_o    = snap_q;

  always_comb begin
    unique case (state_q)
      S_IDLE:  stage_o = 3'd0;
      S_RAMP:  stage_o = lvl_q;
      S_ON:    stage_o = 3'd6;
      default: stage_o = 3'd7;
    endcase
  end

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !en_s_i) |=> (state_q == S_IDLE));

  assert_lvl_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q > $past(lvl_q)) |-> (lvl_q == $past(lvl_q) + 3'd1));

  assert_pgood_rails_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgood_o) |-> $past(&pg_good_i));

  assert_fault_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> ($past(state_q) == S_RAMP || $past(state_q) == S_ON));

  assert_drop_in_teardown_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q < $past(lvl_q)) |-> ($past(state_q) == S_DOWN && !pgood_o));

  assert_fault_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FAULT && en_s_i) |=> (state_q == S_FAULT && fault_q));

  assert_snap_frozen_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && $past(fault_q)) |-> $stable(snap_q));

endmodule

// File: rtl/pwr_group_seq.sv
module pwr_group_seq
  import pseq_pkg::*;
#(
  parameter int FILT_CYC    = 16,
  parameter int TIMEOUT_CYC = 250000,
  parameter int DOWN_DLY    = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mod_en_i,
  input  logic [PG_W-1:0] pg_i,
  output logic [EN_W-1:0] rail_en_o,
  output logic            mod_pgood_o,
  output logic            sys_rst_no,
  output logic            fault_o,
  output logic [2:0]      stat_stage_o,
  output logic [PG_W-1:0] stat_pg_o
);
  logic            en_s;
  logic [PG_W-1:0] pg_good;

  pseq_bit_sync u_en_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (mod_en_i),
    .q_o    (en_s)
  );

  for (genvar g = 0; g < PG_W; g++) begin : g_pg
    pseq_pg_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pg_raw_i (pg_i[g]),
      .good_o   (pg_good[g])
    );
  end

  pseq_ctrl #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .DOWN_DLY    (DOWN_DLY)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_s_i    (en_s),
    .pg_good_i (pg_good),
    .rail_en_o (rail_en_o),
    .pgood_o   (mod_pgood_o),
    .rst_no    (sys_rst_no),
    .fault_o   (fault_o),
    .stage_o   (stat_stage_o),
    .snap_o    (stat_pg_o)
  );

  // enables always form a run of ones from bit 0
  assert_prefix_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((rail_en_o + EN_W'(1)) & rail_en_o) == '0));

  assert_pgood_all_on_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_pgood_o |-> (&rail_en_o && sys_rst_no));

  assert_reset_out_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no |-> !mod_pgood_o);

endmodule

// File: tb/pwr_group_seq_bench.sv
`timescale 1ns/1ps
module pwr_group_seq_bench;
  localparam int FILT = 4;
  localparam int TOUT = 100;
  localparam int DDLY = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b0;
  logic [14:0] pg = '0;
  logic [21:0] rail_en;
  logic        pgood, srst_n, fault;
  logic [2:0]  stage;
  logic [14:0] spg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_group_seq #(.FILT_CYC(FILT), .TIMEOUT_CYC(TOUT), .DOWN_DLY(DDLY)) u_pwr_group_seq (
    .clk_i(clk), .rst_ni(rst_n), .mod_en_i(mod_en), .pg_i(pg),
    .rail_en_o(rail_en), .mod_pgood_o(pgood), .sys_rst_no(srst_n),
    .fault_o(fault), .stat_stage_o(stage), .stat_pg_o(spg));

  // enable masks for groups 1..k enabled
  localparam logic [21:0] LVL_EN [6] = '{22'h0, 22'h7, 22'h3FF, 22'h3FFF, 22'h1FFFFF, 22'h3FFFFF};

  // {pg[14:0], expected stage[2:0], expected enables[21:0]}
  localparam logic [39:0] VEC [7] = '{
    {15'h0000, 3'd1, 22'h000007},
    {15'h0003, 3'd1, 22'h000007},
    {15'h0007, 3'd2, 22'h0003FF},
    {15'h007F, 3'd3, 22'h003FFF},
    {15'h07FF, 3'd4, 22'h1FFFFF},
    {15'h3FFF, 3'd5, 22'h3FFFFF},
    {15'h7FFF, 3'd6, 22'h3FFFFF}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mod_en = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  initial begin
    // R1: reset state
    do_reset();
    check("R1 enables", 32'(rail_en), 0);
    check("R1 pgood", 32'(pgood), 0);
    check("R1 sysrst", 32'(srst_n), 0);
    check("R1 fault", 32'(fault), 0);
    check("R1 stage", 32'(stage), 0);

    // R2: idle ignores good rails while enable is low
    pg = 15'h7FFF;
    tick(30);
    check("R2 enables idle", 32'(rail_en), 0);
    check("R2 stage idle", 32'(stage), 0);

    // R3 R4 R6 R12: table walk of a normal bring-up
    pg = '0;
    do_reset();
    mod_en = 1'b1;
    for (int i = 0; i < 7; i++) begin
      pg = VEC[i][39:25];
      tick(20);
      check("R4 stage step", 32'(stage), 32'(VEC[i][24:22]));
      check("R3 enables step", 32'(rail_en), 32'(VEC[i][21:0]));
      check("R6 pgood step", 32'(pgood), (VEC[i][24:22] == 3'd6) ? 1 : 0);
      check("R12 snapshot step", 32'(spg), 32'(VEC[i][39:25]));
    end
    check("R6 sysrst up", 32'(srst_n), 1);

    // R9 R10: enable drop, stepped teardown
    begin
      logic [21:0] prev;
      int lvl_exp, last_t, nchg;
      bit pg_seen_low;
      prev = rail_en;
      lvl_exp = 5;
      last_t = -1;
      nchg = 0;
      pg_seen_low = 1'b0;
      mod_en = 1'b0;
      for (int t = 1; t <= 80; t++) begin
        tick(1);
        if (t == 4) begin
          check("R10 pgood dropped", 32'(pgood), 0);
          check("R10 sysrst asserted", 32'(srst_n), 0);
          check("R10 stage teardown", 32'(stage), 7);
        end
        if (rail_en != prev) begin
          nchg++;
          lvl_exp--;
          check("R10 group off order", 32'(rail_en), 32'(LVL_EN[lvl_exp < 0 ? 0 : lvl_exp]));
          if (nchg == 1) check("R10 pgood before first drop", 32'(pgood), 0);
          else           check("R10 drop spacing", 32'(t - last_t), DDLY);
          last_t = t;
          prev = rail_en;
        end
      end
      check("R10 groups dropped", 32'(nchg), 5);
      check("R9 no fault", 32'(fault), 0);
      check("R9 back to idle", 32'(stage), 0);
    end

    // R4 R8: pins tied high pass, then loss of a passed rail
    do_reset();
    pg = 15'h7FFF;
    mod_en = 1'b1;
    tick(60);
    check("R4 tied-high bring-up", 32'(stage), 6);
    pg[0] = 1'b0;
    tick(3);
    check("R8 pgood still up before sync", 32'(pgood), 1);
    tick(60);
    check("R8 fault on loss", 32'(fault), 1);
    check("R8 enables off", 32'(rail_en), 0);
    check("R8 stage fault", 32'(stage), 7);
    mod_en = 1'b0;
    tick(10);

    // R5 R7 R11 R12: filter threshold, timeout, latched fault
    pg = '0;
    do_reset();
    mod_en = 1'b1;
    tick(10);
    check("R5 stage1 entered", 32'(stage), 1);
    pg = 15'h0007;
    tick(FILT - 1);
    pg = '0;
    tick(12);
    check("R5 short pulse no advance", 32'(stage), 1);
    pg = 15'h0007;
    tick(12);
    check("R5 held pulse advances", 32'(stage), 2);
    tick(TOUT + 5 * DDLY + 10);
    check("R7 timeout fault", 32'(fault), 1);
    check("R7 enables off", 32'(rail_en), 0);
    check("R12 snapshot at fault", 32'(spg), 32'h0007);
    pg = '0;
    tick(20);
    check("R12 snapshot frozen", 32'(spg), 32'h0007);
    check("R11 fault held", 32'(fault), 1);
    check("R11 no restart", 32'(rail_en), 0);
    check("R11 stage held", 32'(stage), 7);
    mod_en = 1'b0;
    tick(8);
    check("R11 fault cleared", 32'(fault), 0);
    check("R11 idle after clear", 32'(stage), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule